// File: doc/BRIEF.md
# Masked Four-Source Priority Interrupt Controller

This block collects four interrupt request lines from peripheral interfaces and turns them into a single interrupt line to the processor. A rising edge on any request line sets a pending bit. The bit stays set until software clears it, so a request pulse lasting one cycle is not lost. Each pending bit is gated by its own mask bit. A fixed-order priority encoder picks the most urgent surviving request and turns it into a two-bit code.

A global enable bit gates the interrupt line. Software sets and clears this bit with strobes. When the processor acknowledges, the block drives an 8-bit vector onto the data bus during that cycle. The vector's two low bits are the priority code and its six upper bits are zero, so sources 0 to 3 map to vector addresses 0 to 3. The same acknowledge clears the global enable, which holds off further interrupts until software sets it again. Software has per-bit strobes to clear pending bits and to set or clear mask bits.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `data_oe_o` is 0 and `data_o` is 0. All pending bits, all mask bits and the global enable are 0.
- R2: A 0-to-1 change on `req_i[k]` seen at a clock edge sets pending bit k at that edge. The bit stays set while the line falls back to 0. A line held at 1 does not set the bit again after it has been cleared.
- R3: A 1 on `pend_clr_i[k]` clears pending bit k at the next edge. If a new rising edge on `req_i[k]` arrives in the same cycle, the bit stays set.
- R4: A pending bit takes part in priority and in the interrupt only while its mask bit is 1. `mask_set_i[k]` sets mask bit k and `mask_clr_i[k]` clears it. If both are 1 in the same cycle, the clear wins.
- R5: Among the unmasked pending bits, the lowest index has the highest priority. The code is {x,y} with x = !a0 & !a1 and y = (!a0 & a1) | (!a0 & !a2), where a0..a3 are the unmasked pending bits. This gives code 0 for source 0, 1 for source 1, 2 for source 2 and 3 for source 3.
- R6: `irq_o` is 1 exactly when the global enable is 1 and at least one unmasked pending bit exists.
- R7: `ien_set_i` sets the global enable and `ien_clr_i` clears it. If both are 1 in the same cycle, the clear wins.
- R8: While `inta_i` is 1, `data_oe_o` is 1 and `data_o` is {6'b0, x, y} in the same cycle. While `inta_i` is 0, `data_oe_o` is 0 and `data_o` is 0.
- R9: A cycle with `inta_i` at 1 clears the global enable at the next edge. This overrides an `ien_set_i` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Interrupt request lines, index 0 most urgent |
| pend_clr_i | input | 4 | Per-bit clear strobes for the pending register |
| mask_set_i | input | 4 | Per-bit set strobes for the mask register |
| mask_clr_i | input | 4 | Per-bit clear strobes for the mask register |
| ien_set_i | input | 1 | Sets the global enable |
| ien_clr_i | input | 1 | Clears the global enable |
| inta_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Vector address toward the data bus |
| data_oe_o | output | 1 | Bus drive enable for the vector |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a software clear of a pending bit and a fresh rising edge on the same request line. The bench drives both in one cycle and expects the bit to survive. It judges this by the interrupt line and by the vector read back under acknowledge. The second pair is an acknowledge and a software enable set. The bench drives both together and expects `irq_o` to be low after the edge. Directed priority patterns, including gaps such as sources 1 and 3 together, confirm the encoder code on the bus.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int CODE_W  = 2;
  localparam int VEC_W   = 8;
  localparam int PAD_W   = VEC_W - CODE_W;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [VEC_W-1:0]   vec_t;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import prio_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] rise;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_comb begin
      rise[k]   = req_i[k] & ~req_q[k];
      pend_d[k] = (pend_q[k] & ~clr_i[k]) | rise[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[k]  <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        req_q[k]  <= req_i[k];
        pend_q[k] <= pend_d[k];
      end
    end

    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[k] && !clr_i[k]) |=> pend_q[k]);

    // R3
    clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && req_i[k] && !req_q[k]) |=> pend_q[k]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import prio_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;

  always_comb begin
    mask_d = (mask_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R4
    mask_clr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[k] |=> !mask_q[k]);
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import prio_irq_pkg::*;
(
  input  src_vec_t act_i,
  output logic     x_o,
  output logic     y_o,
  output logic     ist_o
);
  always_comb begin
    x_o   = ~act_i[0] & ~act_i[1];
    y_o   = (~act_i[0] & act_i[1]) | (~act_i[0] & ~act_i[2]);
    ist_o = |act_i;
  end
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic ien_o
);
  logic ien_q;
  logic ien_d;

  always_comb begin
    ien_d = ien_q;
    if (set_i)          ien_d = 1'b1;
    if (clr_i || ack_i) ien_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= 1'b0;
    else        ien_q <= ien_d;
  end

  // R7
  ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !ien_q);

  // R7
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !ack_i) |=> ien_q);

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !ien_q);

  assign ien_o = ien_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] pend_clr_i,
  input  logic [NUM_SRC-1:0] mask_set_i,
  input  logic [NUM_SRC-1:0] mask_clr_i,
  input  logic               ien_set_i,
  input  logic               ien_clr_i,
  input  logic               inta_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   data_o,
  output logic               data_oe_o
);
  src_vec_t pend;
  src_vec_t mask;
  src_vec_t act;
  logic     enc_x;
  logic     enc_y;
  logic     ist;
  logic     ien;
  code_t    code;

  irq_pend_reg #(.N(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .clr_i  (pend_clr_i),
    .pend_o (pend)
  );

  irq_mask_reg #(.N(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (mask_set_i),
    .clr_i  (mask_clr_i),
    .mask_o (mask)
  );

  assign act = pend & mask;

  irq_prio_enc u_enc (
    .act_i (act),
    .x_o   (enc_x),
    .y_o   (enc_y),
    .ist_o (ist)
  );

  irq_enable_ctl u_ien (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ien_set_i),
    .clr_i (ien_clr_i),
    .ack_i (inta_i),
    .ien_o (ien)
  );

  assign code = {enc_x, enc_y};

  always_comb begin
    irq_o     = ien & ist;
    data_oe_o = inta_i;
    data_o    = '0;
    if (inta_i) data_o = {{PAD_W{1'b0}}, code};
  end

  // R5
  prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ist && inta_i) |-> (act[data_o[CODE_W-1:0]] &&
      ((act & ((src_vec_t'(1) << data_o[CODE_W-1:0]) - src_vec_t'(1))) == '0)));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend & mask) != '0));

  // R8
  vec_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (data_o[VEC_W-1:CODE_W] == '0));

  // R8
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_o |-> (data_o == '0));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic [3:0] pclr;
  logic [3:0] mset;
  logic [3:0] mclr;
  logic       ien_set;
  logic       ien_clr;
  logic       inta;
  logic       irq;
  logic [7:0] data;
  logic       oe;

  int n_chk  = 0;
  int n_fail = 0;

  prio_irq_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .pend_clr_i (pclr),
    .mask_set_i (mset),
    .mask_clr_i (mclr),
    .ien_set_i  (ien_set),
    .ien_clr_i  (ien_clr),
    .inta_i     (inta),
    .irq_o      (irq),
    .data_o     (data),
    .data_oe_o  (oe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ien_on();
    ien_set = 1'b1; tick(); ien_set = 1'b0;
  endtask

  task automatic pulse_req(input logic [3:0] p);
    req = p; tick(); req = 4'b0; tick();
  endtask

  task automatic clear_all();
    pclr = 4'hF; tick(); pclr = 4'h0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = '0; pclr = '0; mset = '0; mclr = '0;
    ien_set = 1'b0; ien_clr = 1'b0; inta = 1'b0;
    repeat (3) tick();
    chk("R1 irq in reset", irq, 0);
    chk("R1 oe in reset", oe, 0);
    chk("R1 data in reset", data, 0);
    rst_n = 1'b1; tick();
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_mask();
    ien_on();
    pulse_req(4'b0100);
    chk("R4 masked pending bit gives no irq", irq, 0);
    mset = 4'b0100; tick(); mset = 4'b0;
    chk("R6 unmasked pending bit raises irq", irq, 1);
    mset = 4'b0100; mclr = 4'b0100; tick(); mset = 4'b0; mclr = 4'b0;
    chk("R4 mask clear wins over set", irq, 0);
    mset = 4'hF; tick(); mset = 4'b0;
    chk("R2 pulse held in pending register", irq, 1);
    pclr = 4'b0100; tick(); pclr = 4'b0;
    chk("R3 software clear drops pending bit", irq, 0);
  endtask

  task automatic one_prio(input logic [3:0] p, input int exp);
    pulse_req(p);
    inta = 1'b1; #1;
    chk("R8 oe during ack", oe, 1);
    chk($sformatf("R5 vector for pattern %b", p), data, exp);
    tick(); inta = 1'b0; #1;
    chk("R8 bus released after ack", {oe, data}, 0);
    clear_all();
  endtask

  task automatic t_priority();
    one_prio(4'b1111, 0);
    one_prio(4'b1110, 1);
    one_prio(4'b1100, 2);
    one_prio(4'b1000, 3);
    one_prio(4'b1010, 1);
    one_prio(4'b0101, 0);
  endtask

  task automatic t_ack_collide();
    ien_on();
    pulse_req(4'b1000);
    chk("R6 irq before ack", irq, 1);
    inta = 1'b1; ien_set = 1'b1; #1;
    chk("R8 vector 3 during ack", data, 3);
    tick(); inta = 1'b0; ien_set = 1'b0; #1;
    chk("R9 ack wins over enable set", irq, 0);
    ien_on();
    chk("R7 enable set restores irq", irq, 1);
    clear_all();
  endtask

  task automatic t_ien();
    ien_clr = 1'b1; tick(); ien_clr = 1'b0;
    pulse_req(4'b0001);
    chk("R6 enable low blocks irq", irq, 0);
    ien_on();
    chk("R7 enable set", irq, 1);
    ien_set = 1'b1; ien_clr = 1'b1; tick(); ien_set = 1'b0; ien_clr = 1'b0;
    chk("R7 clear wins over set", irq, 0);
    clear_all();
  endtask

  task automatic t_edge();
    ien_on();
    req = 4'b0010; tick();
    chk("R2 rising edge sets bit", irq, 1);
    pclr = 4'b0010; tick(); pclr = 4'b0;
    chk("R2 held level does not re-set", irq, 0);
    tick();
    chk("R2 still clear while level high", irq, 0);
    req = 4'b0; tick(); req = 4'b0010; tick();
    chk("R2 new edge sets bit again", irq, 1);
    req = 4'b0; clear_all();
  endtask

  task automatic t_race();
    pulse_req(4'b0100);
    req = 4'b0100; pclr = 4'b0100; tick(); req = 4'b0; pclr = 4'b0;
    chk("R3 new edge beats clear", irq, 1);
    inta = 1'b1; #1;
    chk("R3 surviving bit reads vector 2", data, 2);
    tick(); inta = 1'b0;
    clear_all();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_mask();
    t_priority();
    t_ack_collide();
    t_ien();
    t_edge();
    t_race();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule